// File: doc/BRIEF.md
# Multichannel Wilkinson Conversion Backend

This block is the digital half of a ramp-compare converter that digitises a bank of held analog samples. A single Gray-coded counter serves every channel. It advances once per clock while the shared voltage ramp rises. Each channel's comparator is seen here as a one-bit input. The block records the counter value for a channel when that comparator first switches. An extra bit records the level of a half-rate phase input at that same edge.

A start pulse clears all results and begins a conversion. The block drives the ramp enable high while the count runs. The conversion ends when every channel has captured or when the count reaches its top value. At the end, the block drops the ramp enable and pulses done in the same cycle. Results are presented in binary with per-channel valid and overflow flags. They stay stable until the next start. While the ramp enable is low, the ramp is meant to be held discharged.

Top module: `wilkinson_backend`

## Requirements
- R1: After reset, ramp_en_o, done_o, valid_o, ovf_o and result_o are all zero.
- R2: A start_i pulse seen while idle raises ramp_en_o on the next cycle, clears every valid and overflow flag, and restarts the count from zero.
- R3: Suppose a channel's comparator goes high after the k-th rising clock edge that follows the edge sampling start. Its reported count (bits [10:0] of its field) is then k+2, in binary. This covers two synchroniser stages and one capture register.
- R4: Channel c occupies result_o[12c+11:12c]. Bit 11 of that field holds the phase_i level sampled at the capture edge.
- R5: A channel captures only on the first rising edge of its synchronised comparator within a conversion. Later edges do not change its result. A comparator that is already high at start produces no capture.
- R6: The count stops at 2047, and a comparator edge arriving in time to record 2047 is still captured as valid. A channel that has not captured by then reports count 2047 with bit 11 at 0, and its ovf_o bit is set.
- R7: done_o is a one-cycle pulse, and ramp_en_o falls in the same cycle. When every channel captures, done_o appears two cycles after the last capture edge (k_max+4 edges after start). Otherwise it appears 2048 edges after start.
- R8: A start_i pulse during a conversion is ignored. It neither clears results nor restarts the count.
- R9: valid_o and ovf_o are never both set for a channel. At done, every channel has exactly one of the two flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a conversion (ignored while one runs) |
| phase_i | input | 1 | Half-rate phase level, stored as the extra result bit |
| cmp_i | input | 8 | Per-channel comparator outputs, asynchronous |
| ramp_en_o | output | 1 | High while the ramp should rise and the count runs |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| valid_o | output | 8 | Channel captured a comparator edge |
| ovf_o | output | 8 | Channel saw no edge before the count saturated |
| result_o | output | 96 | Eight 12-bit results: phase bit over an 11-bit binary count |

## Verification
The bench builds the block at its default values: eight channels and an 11-bit count. At these values a full saturation run takes about 2048 cycles, so the timeout path is exercised in full. This includes the exact boundary between a last-moment valid capture and an overflow. Eight channels are enough to mix early, late, repeated, pre-asserted and missing comparator edges within a single conversion.

// File: rtl/wlk_pkg.sv
package wlk_pkg;
  localparam int unsigned DEF_CH = 8;
  localparam int unsigned DEF_CW = 11;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/wlk_seq.sv
module wlk_seq
  import wlk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic all_valid_i,
  input  logic cnt_max_i,
  output logic run_o,
  output logic clr_o,
  output logic fin_o,
  output logic done_o
);
  seq_state_t st_q, st_d;
  logic       done_q, done_d;

  always_comb begin
    st_d  = st_q;
    clr_o = 1'b0;
    fin_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d  = ST_RUN;
          clr_o = 1'b1;
        end
      end
      ST_RUN: begin
        if (all_valid_i || cnt_max_i) begin
          st_d  = ST_IDLE;
          fin_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    done_d = fin_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign run_o  = (st_q == ST_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/wlk_gray_cnt.sv
module wlk_gray_cnt #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] gray_o,
  output logic         max_o
);
  logic [W-1:0] bin_q, bin_d;
  logic [W-1:0] gray_q, gray_d;

  always_comb begin
    bin_d = bin_q;
    if (clr_i)     bin_d = '0;
    else if (en_i) bin_d = bin_q + 1'b1;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (clr_i || en_i) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;
  assign max_o  = &bin_q;
endmodule

// File: rtl/wlk_chan.sv
module wlk_chan #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic         fin_i,
  input  logic         cmp_i,
  input  logic         phase_i,
  input  logic [W-1:0] gray_i,
  output logic [W:0]   code_o,
  output logic         valid_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] FULL_BIN  = '1;
  localparam logic [W-1:0] FULL_GRAY = FULL_BIN ^ (FULL_BIN >> 1);

  logic         sync1_q, sync2_q, prev_q;
  logic         rise;
  logic [W:0]   code_q, code_d;
  logic         vld_q, vld_d;
  logic         ovf_q, ovf_d;
  logic         cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= cmp_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise = sync2_q & ~prev_q;

  always_comb begin
    code_d = code_q;
    vld_d  = vld_q;
    ovf_d  = ovf_q;
    if (clr_i) begin
      code_d = '0;
      vld_d  = 1'b0;
      ovf_d  = 1'b0;
    end else if (run_i && rise && !vld_q) begin
      code_d = {phase_i, gray_i};
      vld_d  = 1'b1;
    end else if (fin_i && !vld_q) begin
      code_d = {1'b0, FULL_GRAY};
      ovf_d  = 1'b1;
    end
  end

  assign cap_en = clr_i | run_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      vld_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (cap_en) begin
      code_q <= code_d;
      vld_q  <= vld_d;
      ovf_q  <= ovf_d;
    end
  end

  assign code_o  = code_q;
  assign valid_o = vld_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/wlk_readout.sv
module wlk_readout #(
  parameter int unsigned NCH = 8,
  parameter int unsigned W   = 11
) (
  input  logic [NCH*(W+1)-1:0] codes_i,
  output logic [NCH*(W+1)-1:0] result_o
);
  localparam int unsigned RW = W + 1;

  for (genvar c = 0; c < NCH; c++) begin : g_conv
    logic [W-1:0] g, b;
    assign g = codes_i[c*RW +: W];
    always_comb begin
      b[W-1] = g[W-1];
      for (int i = W - 2; i >= 0; i--) begin
        b[i] = b[i+1] ^ g[i];
      end
    end
    assign result_o[c*RW +: RW] = {codes_i[c*RW + W], b};
  end
endmodule

// File: rtl/wilkinson_backend.sv
module wilkinson_backend
  import wlk_pkg::*;
#(
  parameter int unsigned NCH = DEF_CH,
  parameter int unsigned CW  = DEF_CW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  phase_i,
  input  logic [NCH-1:0]        cmp_i,
  output logic                  ramp_en_o,
  output logic                  done_o,
  output logic [NCH-1:0]        valid_o,
  output logic [NCH-1:0]        ovf_o,
  output logic [NCH*(CW+1)-1:0] result_o
);
  localparam int unsigned RW = CW + 1;

  logic          rst_meta_q, rst_int_n;
  logic          run, clr, fin, cnt_max;
  logic [CW-1:0] gray;
  logic [NCH*RW-1:0] codes;
  logic [NCH-1:0] vld, ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  wlk_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .all_valid_i (&vld),
    .cnt_max_i   (cnt_max),
    .run_o       (run),
    .clr_o       (clr),
    .fin_o       (fin),
    .done_o      (done_o)
  );

  wlk_gray_cnt #(.W(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (clr),
    .en_i   (run & ~fin),
    .gray_o (gray),
    .max_o  (cnt_max)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wlk_chan #(.W(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr_i   (clr),
      .run_i   (run),
      .fin_i   (fin),
      .cmp_i   (cmp_i[c]),
      .phase_i (phase_i),
      .gray_i  (gray),
      .code_o  (codes[c*RW +: RW]),
      .valid_o (vld[c]),
      .ovf_o   (ovf[c])
    );
  end

  wlk_readout #(.NCH(NCH), .W(CW)) u_rd (
    .codes_i  (codes),
    .result_o (result_o)
  );

  assign ramp_en_o = run;
  assign valid_o   = vld;
  assign ovf_o     = ovf;
endmodule

// File: rtl/wlk_checker.sv
module wlk_checker #(
  parameter int unsigned NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           ramp_en_o,
  input logic           done_o,
  input logic [NCH-1:0] valid_o,
  input logic [NCH-1:0] ovf_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_RAMP_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ramp_en_o && $past(ramp_en_o))); // R7
  AST_RAMP_FALL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ramp_en_o) |-> done_o); // R7
  AST_RAMP_RISE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_en_o) |-> $past(start_i)); // R2
  AST_RISE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_en_o) |-> (valid_o == '0 && ovf_o == '0)); // R2
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en_o && $past(ramp_en_o)) |-> ((valid_o & $past(valid_o)) == $past(valid_o))); // R8
  AST_NO_OVF_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en_o |-> (ovf_o == '0)); // R6
  AST_FLAGS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o & ovf_o) == '0); // R9
  AST_ALL_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((valid_o | ovf_o) == '1)); // R9
endmodule

bind wilkinson_backend wlk_checker #(.NCH(NCH)) u_wlk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .ramp_en_o (ramp_en_o),
  .done_o    (done_o),
  .valid_o   (valid_o),
  .ovf_o     (ovf_o)
);

// File: tb/wilkinson_backend_bench.sv
module wilkinson_backend_bench;
  localparam int NCH = 8;
  localparam int RW  = 12;
  localparam int MAXC = 2047;

  logic clk, rst_n, start_i, phase_i;
  logic [NCH-1:0] cmp_i;
  logic ramp_en_o, done_o;
  logic [NCH-1:0] valid_o, ovf_o;
  logic [NCH*RW-1:0] result_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int         ch;
    logic [11:0] res;
    bit         vld;
    bit         ovf;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  wilkinson_backend u_wilkinson_backend (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
    .cmp_i(cmp_i), .ramp_en_o(ramp_en_o), .done_o(done_o),
    .valid_o(valid_o), .ovf_o(ovf_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected items when a conversion reports done
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      chk(ramp_en_o == 1'b0, "R7 ramp low with done", ramp_en_o, 0);
      for (int c = 0; c < NCH; c++) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "scoreboard empty", 0, 1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(result_o[e.ch*RW +: RW] == e.res, e.req,
              int'(result_o[e.ch*RW +: RW]), int'(e.res));
          chk(valid_o[e.ch] == e.vld && ovf_o[e.ch] == e.ovf, {e.req, " flags R9"},
              int'({valid_o[e.ch], ovf_o[e.ch]}), int'({e.vld, e.ovf}));
        end
      end
    end
  end

  // Driver: pushes expectations, then drives one conversion
  task automatic run_conv(input int dly[NCH], input bit ph, input int glitch_ch,
                          input logic [NCH-1:0] pre_high, input int restart_at,
                          input string req);
    int  exp_done;
    int  kmax;
    bit  all_cap;
    all_cap = 1'b1;
    kmax = 0;
    for (int c = 0; c < NCH; c++) begin
      exp_t e;
      e.ch  = c;
      e.req = req;
      if (dly[c] >= 0 && dly[c] + 2 <= MAXC) begin
        e.res = {ph, 11'(dly[c] + 2)};
        e.vld = 1'b1;
        e.ovf = 1'b0;
        if (dly[c] > kmax) kmax = dly[c];
      end else begin
        e.res = {1'b0, 11'(MAXC)};
        e.vld = 1'b0;
        e.ovf = 1'b1;
        all_cap = 1'b0;
      end
      sb_q.push_back(e);
    end
    exp_done = all_cap ? kmax + 4 : MAXC + 1;

    @(negedge clk);
    phase_i = ph;
    cmp_i   = pre_high;
    repeat (4) @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < NCH; c++) if (dly[c] == 0) cmp_i[c] = 1'b1;
    for (int n = 1; n < 2200; n++) begin
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      if (n == 1) chk(ramp_en_o == 1'b1 && valid_o == '0 && ovf_o == '0,
                      "R2 ramp up and flags cleared", ramp_en_o, 1);
      if (done_o) begin
        chk(n == exp_done, "R7 done timing", n, exp_done);
        break;
      end
      for (int c = 0; c < NCH; c++) if (dly[c] == n) cmp_i[c] = 1'b1;
      if (glitch_ch >= 0) begin
        if (n == dly[glitch_ch] + 4) cmp_i[glitch_ch] = 1'b0;
        if (n == dly[glitch_ch] + 8) cmp_i[glitch_ch] = 1'b1;
      end
      if (n == restart_at) start_i = 1'b1;
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done single cycle", done_o, 0);
    cmp_i = '0;
    repeat (4) @(negedge clk);
    chk(ramp_en_o == 1'b0, "R7 stays idle", ramp_en_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int d_a[NCH] = '{3, 10, 0, 25, 7, 14, 1, 40};
    int d_b[NCH] = '{100, 5, 60, 61, 2, 33, 90, 120};
    int d_c[NCH] = '{2045, 2046, -1, 0, 500, 1000, -1, 7};
    int d_d[NCH] = '{0, 0, 0, 0, 0, 0, 0, 0};
    rst_n   = 1'b0;
    start_i = 1'b0;
    phase_i = 1'b0;
    cmp_i   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ramp_en_o == 0 && done_o == 0, "R1 control outputs idle",
        int'({ramp_en_o, done_o}), 0);
    chk(valid_o == '0 && ovf_o == '0, "R1 flags clear", int'({valid_o, ovf_o}), 0);
    chk(result_o == '0, "R1 results clear", int'(result_o[31:0]), 0);

    // R3: distinct edge times, phase low
    run_conv(d_a, 1'b0, -1, '0, -1, "R3 count value");
    // R4 phase bit, R5 second edge ignored on ch1, R8 start mid-run ignored
    run_conv(d_b, 1'b1, 1, '0, 30, "R4 R5 R8 phase and single capture");
    // R6 saturation boundary, R5 pre-asserted comparator on ch6
    run_conv(d_c, 1'b0, -1, 8'b0100_0000, -1, "R6 R5 timeout and boundary");
    // R3 earliest possible capture on every channel
    run_conv(d_d, 1'b1, -1, '0, -1, "R3 R4 earliest capture");

    chk(sb_q.size() == 0, "R7 every conversion reported done", sb_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule